// File: doc/BRIEF.md
# Push-Button Wake and Reset Controller

This block measures how long an active-low push-button has been held low and turns that hold time into host notifications and a system reset. A short hold, reaching the wake threshold, raises a wake flag and a fixed-width interrupt pulse. A long hold, reaching the reset threshold, raises further flags, another interrupt pulse and a single reset pulse of programmable length. The button is already debounced and synchronous. Supply conditions arrive as digital qualifiers.

Hold time is counted in timebase ticks. A tick is produced every `TICK_DIV` clocks, and each threshold table unit is `UNIT_TICKS` ticks, so a unit is one millisecond with the default values. Status flags are sticky and clear on a read strobe. After each reset the block latches a recovery action. That action tells the power-path logic whether to enter ship mode, enter high impedance or resume, and whether the system rail must be turned back on.

Top module: `pbtn_ctrl`

## Requirements
- R1: The hold count advances only while `btn_n` is 0 and the button is qualified (`bat_ok`, or both `vin_ok` and `chg_en`). An unqualified press produces no flags, no interrupt and no reset.
- R2: The wake thresholds, in table units, are 50, 100, 250 and 500 for `wake_code` 0 to 3. `int_o` rises and `flags[0]` is set on the tick at which the count of ticks with the button held reaches the wake threshold. With one tick per clock, this is the W-th rising edge that sees the button low.
- R3: Each interrupt pulse on `int_o` lasts exactly `INT_TICKS` ticks.
- R4: The reset thresholds are 1000, 2000, 4000 and 8000 units for `rst_code` 0 to 3. When the reset threshold is reached, `sys_rst_o` and `int_o` rise together and `flags[2]` is set. `sys_rst_o` stays high for 10, 50, 100 or 200 units, selected by `dur_code` 0 to 3.
- R5: A reset fires at most once per press, however long the hold lasts. A release (`btn_n` = 1) re-arms it for the next press.
- R6: A release before the reset threshold produces no reset and leaves the wake flag set. A release during the reset pulse does not shorten it.
- R7: `flags[1]` is set when the hold reaches the reset threshold, whether or not a reset fires. All three flags are sticky and clear one cycle after `rd_stb`.
- R8: When `rd_stb` and a flag-set event fall in the same cycle, the flag ends up set.
- R9: With `rst_need_vin` = 1, a reset fires only if `vin_in_range` is 1 when the threshold is reached. With `rst_need_vin` = 0, the press alone is enough.
- R10: On each reset, `rec_o` latches one of three codes: 3 (resume) if `vin_ok` is 1; otherwise 1 (ship) if `ship_sel` is 1, else 2 (high impedance). The code is 0 until the first reset.
- R11: On each reset, `sys_reen_o` latches 1 when `sys_en` was 0 and the recovery code is not ship.
- R12: After `rst_n`, `int_o`, `sys_rst_o`, `flags`, `rec_o` and `sys_reen_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_n | input | 1 | Debounced push-button, low when pressed |
| bat_ok | input | 1 | Battery present |
| vin_ok | input | 1 | Input supply valid and stable |
| chg_en | input | 1 | Charging enabled |
| vin_in_range | input | 1 | Input supply between the undervoltage-plus-sleep and overvoltage limits |
| sys_en | input | 1 | System rail currently enabled |
| wake_code | input | 2 | Wake threshold select |
| rst_code | input | 2 | Reset threshold select |
| dur_code | input | 2 | Reset pulse length select |
| rst_need_vin | input | 1 | Reset also requires `vin_in_range` |
| ship_sel | input | 1 | Battery-only recovery: 1 ship, 0 high impedance |
| rd_stb | input | 1 | Status read strobe, clears the flags |
| flags | output | 3 | Sticky flags: bit0 wake, bit1 long hold, bit2 reset fault |
| int_o | output | 1 | Interrupt pulse to the host |
| sys_rst_o | output | 1 | System reset pulse |
| rec_o | output | 2 | Recovery action code |
| sys_reen_o | output | 1 | Re-enable the system rail on recovery |

## Verification
A hold counter that is wrong by even one tick moves the rising edges of `int_o` and `sys_rst_o` away from the exact edge that the threshold tables give, so the error shows on the first press. A lost arm bit shows as a second reset pulse during a long hold, or as no reset on the following press. A wrong flag priority shows as a clear `flags` read right after a strobe that coincided with an event. A wrong pulse counter appears as a pulse that is one or more cycles off, or as a pulse cut short by a release. Recovery latching errors are visible on `rec_o` in the cycle the reset rises.

// File: rtl/pbtn_pkg.sv
// Shared types and threshold tables for the push-button controller.
// Assumes table values are in abstract units later scaled by a tick count.
package pbtn_pkg;

    typedef enum logic [1:0] {
        REC_NONE   = 2'd0,
        REC_SHIP   = 2'd1,
        REC_HIZ    = 2'd2,
        REC_RESUME = 2'd3
    } rec_e;

    localparam int RST_MAX_U = 8000;
    localparam int DUR_MAX_U = 200;

    // Wake hold threshold in units
    function automatic int wake_units(input logic [1:0] code);
        case (code)
            2'd0:    return 50;
            2'd1:    return 100;
            2'd2:    return 250;
            default: return 500;
        endcase
    endfunction

    // Reset hold threshold in units
    function automatic int rst_units(input logic [1:0] code);
        case (code)
            2'd0:    return 1000;
            2'd1:    return 2000;
            2'd2:    return 4000;
            default: return RST_MAX_U;
        endcase
    endfunction

    // Reset pulse length in units
    function automatic int dur_units(input logic [1:0] code);
        case (code)
            2'd0:    return 10;
            2'd1:    return 50;
            2'd2:    return 100;
            default: return DUR_MAX_U;
        endcase
    endfunction

endpackage

// File: rtl/pbtn_tick.sv
// Timebase divider: one-cycle tick every DIV clocks.
// Assumes DIV >= 1; with DIV = 1 the tick is permanently high.
module pbtn_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Wrap the divider counter at DIV-1
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/pbtn_hold.sv
// Hold timer: counts ticks while the qualified button is low and flags
// the wake, long-hold and reset crossings; keeps the once-per-press arm.
// Assumes thresholds are below the counter saturation value.
module pbtn_hold #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              btn_n,
    input  logic              qual,
    input  logic [HOLD_W-1:0] wake_th,
    input  logic [HOLD_W-1:0] rst_th,
    input  logic              need_vin,
    input  logic              vin_rng,
    output logic              wake_evt,
    output logic              long_evt,
    output logic              rst_evt,
    output logic              armed
);
    localparam logic [HOLD_W-1:0] SAT = '1;

    logic              pressed;
    logic              step;
    logic [HOLD_W-1:0] hold;
    logic [HOLD_W:0]   nxt;

    assign pressed  = !btn_n && qual;
    assign step     = pressed && tick;
    assign nxt      = {1'b0, hold} + 1'b1;
    assign wake_evt = step && (nxt == {1'b0, wake_th});
    assign long_evt = step && (nxt == {1'b0, rst_th});
    assign rst_evt  = long_evt && armed && (!need_vin || vin_rng);

    // Count qualified hold ticks, clear on release or loss of qualification
    always_ff @(posedge clk) begin
        if (!rst_n || !pressed)      hold <= '0;
        else if (step && hold != SAT) hold <= hold + 1'b1;
    end

    // Disarm on a fired reset, re-arm on release
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b1;
        else if (rst_evt) armed <= 1'b0;
        else if (btn_n)   armed <= 1'b1;
    end
endmodule

// File: rtl/pbtn_pulse.sv
// Tick-timed pulse generator: start loads a length, output stays high
// until that many ticks have elapsed. A new start restarts the count.
// Assumes start is a single-cycle strobe.
module pbtn_pulse #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          out
);
    logic [CW-1:0] cnt;

    // Load on start, otherwise count down on ticks
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (start)             cnt <= len;
        else if (tick && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign out = (cnt != '0);
endmodule

// File: rtl/pbtn_ctrl.sv
// Push-button wake and reset controller top. Times a debounced active-low
// button, raises sticky flags, interrupt and reset pulses, and latches the
// recovery action. Assumes all inputs are synchronous to clk.
module pbtn_ctrl
    import pbtn_pkg::*;
#(
    parameter int TICK_DIV   = 125,
    parameter int UNIT_TICKS = 1000,
    parameter int INT_TICKS  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_n,
    input  logic       bat_ok,
    input  logic       vin_ok,
    input  logic       chg_en,
    input  logic       vin_in_range,
    input  logic       sys_en,
    input  logic [1:0] wake_code,
    input  logic [1:0] rst_code,
    input  logic [1:0] dur_code,
    input  logic       rst_need_vin,
    input  logic       ship_sel,
    input  logic       rd_stb,
    output logic [2:0] flags,
    output logic       int_o,
    output logic       sys_rst_o,
    output logic [1:0] rec_o,
    output logic       sys_reen_o
);
    localparam int HOLD_W = $clog2(RST_MAX_U * UNIT_TICKS + 2);
    localparam int DUR_W  = $clog2(DUR_MAX_U * UNIT_TICKS + 1);
    localparam int INT_W  = $clog2(INT_TICKS + 1);

    logic              tick;
    logic              qual;
    logic              wake_evt;
    logic              long_evt;
    logic              rst_evt;
    logic              armed;
    logic [HOLD_W-1:0] wake_th;
    logic [HOLD_W-1:0] rst_th;
    logic [DUR_W-1:0]  dur_len;
    logic [2:0]        flags_q;
    rec_e              rec_q;
    rec_e              rec_d;
    logic              reen_q;

    assign qual    = bat_ok || (vin_ok && chg_en);
    assign wake_th = HOLD_W'(wake_units(wake_code) * UNIT_TICKS);
    assign rst_th  = HOLD_W'(rst_units(rst_code) * UNIT_TICKS);
    assign dur_len = DUR_W'(dur_units(dur_code) * UNIT_TICKS);

    pbtn_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    pbtn_hold #(.HOLD_W(HOLD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n), .qual(qual),
        .wake_th(wake_th), .rst_th(rst_th), .need_vin(rst_need_vin),
        .vin_rng(vin_in_range), .wake_evt(wake_evt), .long_evt(long_evt),
        .rst_evt(rst_evt), .armed(armed)
    );

    pbtn_pulse #(.CW(INT_W)) u_int (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(wake_evt || rst_evt),
        .len(INT_W'(INT_TICKS)), .out(int_o)
    );

    pbtn_pulse #(.CW(DUR_W)) u_rst (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(rst_evt),
        .len(dur_len), .out(sys_rst_o)
    );

    // Sticky flags: a set event wins over a same-cycle read clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q[0] <= wake_evt || (flags_q[0] && !rd_stb);
            flags_q[1] <= long_evt || (flags_q[1] && !rd_stb);
            flags_q[2] <= rst_evt  || (flags_q[2] && !rd_stb);
        end
    end

    // Recovery choice from the supplies present at the reset moment
    always_comb begin
        if (vin_ok)        rec_d = REC_RESUME;
        else if (ship_sel) rec_d = REC_SHIP;
        else               rec_d = REC_HIZ;
    end

    // Latch recovery action and rail re-enable on each fired reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q  <= REC_NONE;
            reen_q <= 1'b0;
        end else if (rst_evt) begin
            rec_q  <= rec_d;
            reen_q <= !sys_en && (rec_d != REC_SHIP);
        end
    end

    assign flags      = flags_q;
    assign rec_o      = rec_q;
    assign sys_reen_o = reen_q;
endmodule

// File: rtl/pbtn_ctrl_chk.sv
// Property checker for pbtn_ctrl, attached by bind. Observes ports and
// the internal event strobes; drives nothing.
module pbtn_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       btn_n,
    input logic       rd_stb,
    input logic       rst_need_vin,
    input logic       vin_in_range,
    input logic [2:0] flags,
    input logic       int_o,
    input logic       sys_rst_o,
    input logic [1:0] rec_o,
    input logic       wake_evt,
    input logic       long_evt,
    input logic       rst_evt,
    input logic       armed
);
    assert_wake_int_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> int_o);

    assert_rst_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> (flags[2] && int_o));

    assert_rst_needs_press_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(!btn_n));

    assert_once_per_press_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> !armed);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !rd_stb) |=> flags[0]);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wake_evt && !long_evt && !rst_evt) |=> (flags == 3'b000));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && wake_evt) |=> flags[0]);

    assert_vin_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> ($past(!rst_need_vin) || $past(vin_in_range)));

    assert_rec_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> (rec_o != 2'd0));
endmodule

bind pbtn_ctrl pbtn_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .rd_stb(rd_stb),
    .rst_need_vin(rst_need_vin), .vin_in_range(vin_in_range),
    .flags(flags), .int_o(int_o), .sys_rst_o(sys_rst_o), .rec_o(rec_o),
    .wake_evt(wake_evt), .long_evt(long_evt), .rst_evt(rst_evt),
    .armed(armed)
);

// File: tb/tb_pbtn_ctrl.sv
// Bench: one tick per clock, one unit per tick, short interrupt pulse.
module tb_pbtn_ctrl;
    localparam int IT = 16;

    logic clk = 1'b0;
    logic rst_n, btn_n, bat_ok, vin_ok, chg_en, vin_in_range, sys_en;
    logic [1:0] wake_code, rst_code, dur_code;
    logic rst_need_vin, ship_sel, rd_stb;
    logic [2:0] flags;
    logic int_o, sys_rst_o, sys_reen_o;
    logic [1:0] rec_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int exp_rec  = 0;
    int exp_reen = 0;

    always #4 clk = ~clk;

    pbtn_ctrl #(.TICK_DIV(1), .UNIT_TICKS(1), .INT_TICKS(IT)) dut (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .bat_ok(bat_ok),
        .vin_ok(vin_ok), .chg_en(chg_en), .vin_in_range(vin_in_range),
        .sys_en(sys_en), .wake_code(wake_code), .rst_code(rst_code),
        .dur_code(dur_code), .rst_need_vin(rst_need_vin),
        .ship_sel(ship_sel), .rd_stb(rd_stb), .flags(flags), .int_o(int_o),
        .sys_rst_o(sys_rst_o), .rec_o(rec_o), .sys_reen_o(sys_reen_o)
    );

    function automatic int tw(input logic [1:0] c);
        return (c == 0) ? 50 : (c == 1) ? 100 : (c == 2) ? 250 : 500;
    endfunction
    function automatic int tr(input logic [1:0] c);
        return 1000 << c;
    endfunction
    function automatic int td(input logic [1:0] c);
        return (c == 0) ? 10 : (c == 1) ? 50 : (c == 2) ? 100 : 200;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One press from the current negedge, checked every cycle.
    task automatic run_press(input int low_len, input int rd_j, input string req);
        int w, r, d, total;
        bit q, wk, lg, fr;
        w  = tw(wake_code);
        r  = tr(rst_code);
        d  = td(dur_code);
        q  = bat_ok || (vin_ok && chg_en);
        wk = q && (low_len >= w);
        lg = q && (low_len >= r);
        fr = lg && (!rst_need_vin || vin_in_range);
        total = low_len;
        if (fr && r + d > total) total = r + d;
        if (w + IT > total) total = w + IT;
        total += 5;
        btn_n = 1'b0;
        for (int j = 1; j <= total; j++) begin
            bit ei, er;
            @(negedge clk);
            ei = (wk && j >= w && j < w + IT) || (fr && j >= r && j < r + IT);
            er = fr && j >= r && j < r + d;
            chk(int_o == ei, {req, " int_o"}, int_o, ei);
            chk(sys_rst_o == er, {req, " sys_rst_o"}, sys_rst_o, er);
            if (j == low_len) btn_n = 1'b1;
            rd_stb = (j == rd_j);
        end
        rd_stb = 1'b0;
        chk(flags == {fr, lg, wk}, {req, " R7 flags"}, flags, {fr, lg, wk});
        if (fr) begin
            exp_rec  = vin_ok ? 3 : (ship_sel ? 1 : 2);
            exp_reen = (!sys_en && exp_rec != 1) ? 1 : 0;
        end
        chk(rec_o == exp_rec, {req, " R10 rec_o"}, rec_o, exp_rec);
        chk(sys_reen_o == exp_reen, {req, " R11 sys_reen_o"}, sys_reen_o, exp_reen);
        repeat (3) @(negedge clk);
    endtask

    task automatic read_clear(input string req);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(flags == 3'b000, {req, " R7 clear on read"}, flags, 0);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 0; btn_n = 1; bat_ok = 0; vin_ok = 0; chg_en = 0;
        vin_in_range = 0; sys_en = 1; wake_code = 0; rst_code = 0;
        dur_code = 0; rst_need_vin = 0; ship_sel = 0; rd_stb = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk({int_o, sys_rst_o, sys_reen_o} == 3'b000, "R12 pulses idle", {int_o, sys_rst_o, sys_reen_o}, 0);
        chk(flags == 0, "R12 flags", flags, 0);
        chk(rec_o == 0, "R12 rec_o", rec_o, 0);

        // R1: unqualified presses do nothing
        run_press(1100, 0, "R1 no supply");
        vin_ok = 1;
        run_press(1100, 0, "R1 vin without charge");
        vin_ok = 0;

        // R2 R3: wake sweep
        bat_ok = 1;
        for (int c = 0; c < 4; c++) begin
            wake_code = 2'(c);
            run_press(tw(2'(c)) + 30, 0, "R2 R3 wake sweep");
            read_clear("R2");
        end

        // R4 R5 R10 R11: reset threshold and duration sweep, held long
        for (int c = 0; c < 4; c++) begin
            rst_code = 2'(c);
            dur_code = 2'(3 - c);
            ship_sel = c[0];
            sys_en   = c[1];
            run_press(tr(2'(c)) + td(2'(3 - c)) + 60, 0, "R4 R5 reset sweep");
            read_clear("R4");
        end

        // R6: release during pulse, then release before threshold
        rst_code = 0; dur_code = 3; wake_code = 1;
        run_press(1002, 0, "R6 release in pulse");
        read_clear("R6");
        run_press(999, 0, "R6 early release");
        read_clear("R6");

        // R8: read strobe coincident with the wake event
        run_press(tw(wake_code) + 10, tw(wake_code) - 1, "R8 set over read");
        read_clear("R8");

        // R9: gated on input supply range
        rst_need_vin = 1; vin_in_range = 0;
        run_press(1050, 0, "R9 out of range");
        read_clear("R9");
        vin_in_range = 1; vin_ok = 1; sys_en = 0;
        run_press(1050, 0, "R9 R10 R11 in range resume");
        read_clear("R9");

        // R1 R5: qualified by input supply alone, re-armed after release
        bat_ok = 0; chg_en = 1; rst_need_vin = 0;
        run_press(1020, 0, "R1 R5 vin only");
        read_clear("R5");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule